// File: doc/BRIEF.md
# Byte EEPROM Access Controller

This block sits between a CPU register bus and an on-chip byte-wide nonvolatile array that has its own address space, separate from data RAM. Software sees four byte registers: two that together hold a 12-bit array address, one data byte, and a control byte. Through the control byte it requests reads, arms and launches writes, and enables a ready interrupt.

Writes are protected by a two-step unlock. Software first sets an arming bit with the launch bit written as zero, and must then set the launch bit within a short window. The launch bit reads back as a busy flag for the whole programming time, a parameter standing in for a programming time of several milliseconds. The array is modelled as a synchronous byte memory that takes the new value when programming finishes. A read request loads the data register from the array two cycles later. The interrupt output is high whenever the interrupt enable is set and no write is in progress.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After reset all four registers read 0x00 and `irq` is low.
- R2: Register index 0 holds address bits 7:0 and index 1 holds address bits 11:8 in its low nibble; bits 7:4 of index 1 always read zero.
- R3: Control register (index 3) layout: bit 3 interrupt enable, bit 2 arm, bit 1 launch/busy, bit 0 read request; bits 7:4 ignore writes and read zero.
- R4: A control write with bit 2 = 1 and bit 1 = 0 sets arm. Arm reads 1 for exactly 4 cycles after that write and then clears by itself. A write launch also clears it.
- R5: A control write with bit 1 = 1 launches a write only if arm reads 1 and no write is busy in that cycle. Otherwise bit 1 is ignored.
- R6: After a launch, bit 1 reads 1 for PROG_CYCLES cycles and then clears. From then on, the addressed array byte holds the data register value.
- R7: A control write with bit 0 = 1 while idle makes bit 0 read 1 for one cycle, and the data register holds the addressed array byte in the cycle after that. The request is ignored while busy and when it comes in the same write that launches programming.
- R8: `irq` is high exactly when the interrupt enable is 1 and no write is busy.
- R9: Writes to the address or data registers while a write is busy leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_widx | input | 2 | Index of the register being written |
| bus_wdata | input | 8 | Write data |
| bus_ridx | input | 2 | Index of the register being read |
| bus_rdata | output | 8 | Read data of the register at `bus_ridx` |
| irq | output | 1 | Ready interrupt |

## Verification
Two pairs of functions can coincide. A read request can arrive in the same control write that launches programming: the bench writes 0x0B right after arming, and expects busy set, the read bit clear and the data register unchanged. The end of programming also meets the interrupt enable: the bench sets the enable while busy, and expects `irq` to stay low through every busy cycle and rise in the first idle cycle. A reference model kept in bench integers and an associative array follows every clock and checks each cycle's read data and `irq`.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    RIDX_ADDR_LO = 2'd0,
    RIDX_ADDR_HI = 2'd1,
    RIDX_DATA    = 2'd2,
    RIDX_CTRL    = 2'd3
  } reg_idx_t;

  localparam int CB_RD  = 0;
  localparam int CB_GO  = 1;
  localparam int CB_ARM = 2;
  localparam int CB_IE  = 3;

  function automatic logic [7:0] f_ctrl_pack(input logic ie, input logic arm,
                                             input logic busy, input logic rd);
    logic [7:0] v;
    v = 8'h00;
    v[CB_IE]  = ie;
    v[CB_ARM] = arm;
    v[CB_GO]  = busy;
    v[CB_RD]  = rd;
    return v;
  endfunction

  function automatic logic [7:0] f_addr_hi(input logic [15:0] a);
    return a[15:8];
  endfunction
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic consume_i,
  output logic open_o
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (consume_i)  cnt <= '0;
    else if (set_i)      cnt <= CW'(WIN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign open_o = (cnt != '0);
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
  parameter int CYCLES = 1700000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start_i)   cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
  assign done_o = (cnt == CW'(1));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int UNLOCK_WIN  = 4,
  parameter int PROG_CYCLES = 1700000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_widx,
  input  logic [7:0] bus_wdata,
  input  logic [1:0] bus_ridx,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              ie_q;
  logic              rd_q;
  logic [15:0]       addr16;
  logic [7:0]        arr_rdata;

  // named internal events
  logic ctrl_wr, unlock_set, wr_start, rd_req, arm, busy, prog_done;

  assign ctrl_wr    = bus_we && (reg_idx_t'(bus_widx) == RIDX_CTRL);
  assign unlock_set = ctrl_wr && bus_wdata[CB_ARM] && !bus_wdata[CB_GO];
  assign wr_start   = ctrl_wr && bus_wdata[CB_GO] && arm && !busy;
  assign rd_req     = ctrl_wr && bus_wdata[CB_RD] && !busy && !wr_start;

  nvm_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk(clk), .rst_n(rst_n), .set_i(unlock_set),
    .consume_i(wr_start), .open_o(arm)
  );

  nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(wr_start),
    .busy_o(busy), .done_o(prog_done)
  );

  nvm_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we_i(prog_done), .re_i(rd_req),
    .addr_i(addr_q), .wdata_i(data_q), .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      ie_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= rd_req;
      if (ctrl_wr) ie_q <= bus_wdata[CB_IE];
      if (bus_we && !busy) begin
        if (reg_idx_t'(bus_widx) == RIDX_ADDR_LO) addr_q[7:0] <= bus_wdata;
        if (reg_idx_t'(bus_widx) == RIDX_ADDR_HI)
          addr_q[ADDR_W-1:8] <= bus_wdata[ADDR_W-9:0];
      end
      if (rd_q)
        data_q <= arr_rdata;
      else if (bus_we && !busy && reg_idx_t'(bus_widx) == RIDX_DATA)
        data_q <= bus_wdata;
    end
  end

  assign addr16 = 16'(addr_q);

  always_comb begin
    unique case (reg_idx_t'(bus_ridx))
      RIDX_ADDR_LO: bus_rdata = addr16[7:0];
      RIDX_ADDR_HI: bus_rdata = f_addr_hi(addr16);
      RIDX_DATA:    bus_rdata = data_q;
      RIDX_CTRL:    bus_rdata = f_ctrl_pack(ie_q, arm, busy, rd_q);
      default:      bus_rdata = 8'h00;
    endcase
  end

  assign irq = ie_q && !busy;
endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
module nvm_byte_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int WIN    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ie,
  input logic              arm,
  input logic              busy,
  input logic              prog_done,
  input logic              wr_start,
  input logic              unlock_set,
  input logic              rd_q,
  input logic [ADDR_W-1:0] addr
);
  logic [15:0] arm_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arm_run <= '0;
    else if (unlock_set) arm_run <= 16'd1;
    else if (arm)        arm_run <= arm_run + 16'd1;
    else                 arm_run <= '0;
  end

  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_set |=> arm); // R4
  AST_UNLOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (arm_run <= 16'(WIN))); // R4
  AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> (arm && !busy)); // R5
  AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> busy); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy); // R6
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> !busy); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq); // R8
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && ie) |-> irq); // R8
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr)); // R9
endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(.ADDR_W(ADDR_W), .WIN(UNLOCK_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie_q), .arm(arm), .busy(busy),
  .prog_done(prog_done), .wr_start(wr_start), .unlock_set(unlock_set),
  .rd_q(rd_q), .addr(addr_q)
);

// File: tb/tb_nvm_byte_ctrl.sv
module tb_nvm_byte_ctrl;
  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_widx = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [1:0] bus_ridx = 2'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nvm_byte_ctrl #(.ADDR_W(12), .UNLOCK_WIN(4), .PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_ridx(bus_ridx), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  int m_addr, m_data, m_ie, m_rd, m_arm_left, m_busy_left;
  int m_mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_data = 0; m_ie = 0; m_rd = 0; m_arm_left = 0; m_busy_left = 0;
    end else begin
      automatic bit cw    = bus_we && bus_widx == 2'd3;
      automatic bit go    = cw && bus_wdata[1] && m_arm_left > 0 && m_busy_left == 0;
      automatic bit arm   = cw && bus_wdata[2] && !bus_wdata[1];
      automatic bit rd    = cw && bus_wdata[0] && m_busy_left == 0 && !go;
      automatic bit idle  = (m_busy_left == 0);
      automatic int old_rd = m_rd;
      if (m_busy_left == 1) m_mem[m_addr] = m_data;
      if (m_busy_left > 0) m_busy_left--;
      if (go) begin m_busy_left = P; m_arm_left = 0; end
      else if (arm) m_arm_left = 4;
      else if (m_arm_left > 0) m_arm_left--;
      if (cw) m_ie = bus_wdata[3];
      if (bus_we && idle && bus_widx == 2'd0) m_addr = (m_addr & 32'hF00) | bus_wdata;
      if (bus_we && idle && bus_widx == 2'd1) m_addr = (m_addr & 32'h0FF) | ((bus_wdata & 8'h0F) << 8);
      if (old_rd != 0) m_data = m_mem.exists(m_addr) ? m_mem[m_addr] : 0;
      else if (bus_we && idle && bus_widx == 2'd2) m_data = bus_wdata;
      m_rd = rd;
    end
  end

  function automatic int model_rdata(input logic [1:0] idx);
    case (idx)
      2'd0: return m_addr & 8'hFF;
      2'd1: return (m_addr >> 8) & 8'h0F;
      2'd2: return m_data;
      default: return (m_ie << 3) | ((m_arm_left > 0) << 2) | ((m_busy_left > 0) << 1) | m_rd;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      case (bus_ridx)
        2'd0, 2'd1: chk("R2 model addr", bus_rdata, model_rdata(bus_ridx));
        2'd2:       chk("R7 model data", bus_rdata, model_rdata(bus_ridx));
        default:    chk("R3 model ctrl", bus_rdata, model_rdata(bus_ridx));
      endcase
      chk("R8 model irq", irq, (m_ie != 0 && m_busy_left == 0) ? 1 : 0);
    end
  end

  int rot = 0;
  task automatic bus(input logic we, input logic [1:0] wi, input logic [7:0] wd);
    @(negedge clk); #1;
    bus_we = we; bus_widx = wi; bus_wdata = wd;
    bus_ridx = 2'(rot); rot++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus(1'b0, 2'd0, 8'h00);
  endtask

  task automatic peek(input logic [1:0] idx, input int exp, input string tag);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_ridx = idx;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(2'd0, 8'h00, "R1 addr lo");
    peek(2'd1, 8'h00, "R1 addr hi");
    peek(2'd2, 8'h00, "R1 data");
    peek(2'd3, 8'h00, "R1 ctrl");
    chk("R1 irq", irq, 0);
    // R2 address registers, reserved upper nibble
    bus(1'b1, 2'd0, 8'h34);
    bus(1'b1, 2'd1, 8'hF5);
    peek(2'd1, 8'h05, "R2 addr hi");
    peek(2'd0, 8'h34, "R2 addr lo");
    bus(1'b1, 2'd2, 8'hA5);
    // R5 launch without arm ignored
    bus(1'b1, 2'd3, 8'h02);
    peek(2'd3, 8'h00, "R5 launch without arm");
    // R4 arm expires after 4 cycles
    bus(1'b1, 2'd3, 8'h04);
    idle(4);
    bus(1'b1, 2'd3, 8'h02);
    peek(2'd3, 8'h00, "R4 late launch rejected");
    // R6 launch and busy, R9 writes ignored, R7 read ignored, R8 irq held low
    bus(1'b1, 2'd3, 8'h04);
    bus(1'b1, 2'd3, 8'h02);
    peek(2'd3, 8'h02, "R6 busy after launch");
    bus(1'b1, 2'd0, 8'h99);
    bus(1'b1, 2'd2, 8'h77);
    bus(1'b1, 2'd3, 8'h09);
    peek(2'd3, 8'h0A, "R7 read ignored while busy");
    chk("R8 irq low while busy", irq, 0);
    peek(2'd0, 8'h34, "R9 addr frozen");
    peek(2'd2, 8'hA5, "R9 data frozen");
    idle(P);
    peek(2'd3, 8'h08, "R6 busy cleared");
    chk("R8 irq after done", irq, 1);
    // R7 read back programmed byte
    bus(1'b1, 2'd2, 8'h11);
    bus(1'b1, 2'd3, 8'h09);
    peek(2'd2, 8'hA5, "R7 read data");
    // R7 read and launch in same write: launch wins
    bus(1'b1, 2'd0, 8'h10);
    bus(1'b1, 2'd2, 8'h3C);
    bus(1'b1, 2'd3, 8'h04);
    bus(1'b1, 2'd3, 8'h0B);
    peek(2'd3, 8'h0A, "R7 read dropped on launch");
    peek(2'd2, 8'h3C, "R7 data unchanged");
    idle(P + 2);
    bus(1'b1, 2'd3, 8'h09);
    peek(2'd2, 8'h3C, "R6 second byte programmed");
    // R5 both bits without prior arm: nothing happens, ie cleared
    bus(1'b1, 2'd3, 8'h06);
    peek(2'd3, 8'h00, "R5 arm and launch together");
    chk("R8 irq disabled", irq, 0);
    // R4 launch on the 4th cycle accepted
    bus(1'b1, 2'd3, 8'h04);
    idle(3);
    bus(1'b1, 2'd3, 8'h02);
    peek(2'd3, 8'h02, "R4 launch at window edge");
    idle(P + 2);
    // R3 reserved control bits
    bus(1'b1, 2'd3, 8'hF8);
    peek(2'd3, 8'h08, "R3 reserved bits");
    idle(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule